// File: doc/BRIEF.md
# Refresh-Hiding Pseudo-Static Memory Controller

This block wraps a storage array built from small dynamic-style banks and presents it as an ordinary synchronous static memory. The port has an enable, a write enable, an address and write data. Reads return one word with a fixed latency of one cycle. There is no busy or wait signal, and the port accepts a new request on every clock. Each access opens one row of exactly one bank and restores it. In that same cycle, every bank that is not being used refreshes the row at its own refresh pointer. The pointer steps round-robin through the rows.

A row cache is indexed by row number and tagged with the bank that owns the entry, so it holds as many rows as one bank. An access that hits the cache leaves its bank free, and that bank refreshes during the cycle. A hammered row therefore cannot starve its bank of refresh. A write that hits the cache marks the entry dirty. When a miss on the same row index replaces a dirty entry, the entry is written back to its owning bank in that same cycle. That bank is always a different bank from the one the miss opens.

Each bank row has a behavioural model with a refresh-age counter. The age counts the cycles since the row was last restored, whether by an access, a write-back or the refresh pointer. No age may reach `RETENTION_CYCLES`.

Top module: `psram_refresh_hider`

## Requirements
- R1: While `rstN` is low and after its release, `rdData` is zero until the first read completes. All cache entries are invalid, and every refresh pointer and age counter is zero.
- R2: The address is split from the top bit down as {bank index, row index, word index}. With the default parameters these fields are 2, 7 and 3 bits wide. A read presented at one clock edge drives the selected 32-bit word of the 256-bit row on `rdData` after that edge.
- R3: A write replaces only the addressed word. The other words of the same row keep their earlier contents.
- R4: Rows with the same row index in different banks hold independent data. A miss fills the cache entry, so an access to the same bank and row in the next cycle is a cache hit.
- R5: Data written into a cached row survives the eviction of that entry. The write-back targets the owning bank, which is never the bank opened by the evicting access.
- R6: `rdData` keeps its last read value through write cycles and idle cycles.
- R7: Requests presented on consecutive cycles are all accepted without stall, and each read returns its own word one cycle later.
- R8: A bank that is neither accessed nor written back in a cycle refreshes the row at its pointer, and the pointer advances by one, wrapping from the last row to row 0. A busy bank holds its pointer. Refresh never alters stored data.
- R9: An access, write-back or refresh resets the age of that row to zero. No row's age ever reaches `RETENTION_CYCLES`, and at most two banks are busy in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqEn | input | 1 | Request valid in this cycle |
| reqWe | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (12) | {bank, row, word} address |
| wrData | input | WORD_BITS (32) | Write data |
| rdData | output | WORD_BITS (32) | Read data, one cycle after the read |

## Verification
On every cycle, the assertions check the refresh pointer's advance and hold rules, the clearing of a row's age when it is touched, the retention limit for every row of every bank, the limit of two busy banks, the rule that a write-back never targets the bank being opened, and the rule that a fill is followed by a hit. Only the directed scenarios can show data correctness at the port. These cover word merging inside a row, separation between banks at the same row index, dirty data surviving an eviction, held read data, back-to-back throughput, and contents surviving long idle stretches and same-row hammering.

// File: rtl/psram_pkg.sv
package psram_pkg;
  // Strobes from the tag/decision logic to the storage datapath
  typedef struct packed {
    logic access;      // open the addressed bank row (cache miss)
    logic accessWrite; // the miss is a write: merged row goes to bank and cache
    logic writeback;   // evicted dirty entry goes back to its owning bank
    logic hitWrite;    // write hit: update the cached word only
    logic readHit;     // read served from the cache
    logic readMiss;    // read served from the opened bank row
  } strobe_t;
endpackage

// File: rtl/psram_bank.sv
module psram_bank #(
  parameter int ROWS             = 128,
  parameter int ROW_BITS         = 256,
  parameter int RETENTION_CYCLES = 1024,
  localparam int ROW_W = $clog2(ROWS),
  localparam int AGE_W = $clog2(RETENTION_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busy,
  input  logic                rowWe,
  input  logic [ROW_W-1:0]    rowIdx,
  input  logic [ROW_BITS-1:0] rowIn,
  output logic [ROW_BITS-1:0] rowOut
);
  logic [ROW_BITS-1:0] mem [ROWS];
  logic [ROW_W-1:0]    refPtr;
  logic [AGE_W-1:0]    age [ROWS];
  logic                anyExpired;

  assign rowOut = mem[rowIdx];

  always_ff @(posedge clk) begin
    if (busy && rowWe) mem[rowIdx] <= rowIn;
  end

  // Round-robin refresh pointer: moves only in cycles the bank is free
  always_ff @(posedge clk) begin
    if (!rstN)      refPtr <= '0;
    else if (!busy) refPtr <= (refPtr == ROW_W'(ROWS - 1)) ? '0 : refPtr + 1'b1;
  end

  // Behavioural retention tracker
  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (!rstN)                                  age[r] <= '0;
      else if (busy && ROW_W'(r) == rowIdx)       age[r] <= '0;
      else if (!busy && ROW_W'(r) == refPtr)      age[r] <= '0;
      else if (age[r] < AGE_W'(RETENTION_CYCLES)) age[r] <= age[r] + 1'b1;
    end
  end

  always_comb begin
    anyExpired = 1'b0;
    for (int r = 0; r < ROWS; r++)
      if (age[r] >= AGE_W'(RETENTION_CYCLES)) anyExpired = 1'b1;
  end

  p_ptr_advance_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> refPtr == (($past(refPtr) == ROW_W'(ROWS - 1)) ? '0 : $past(refPtr) + 1'b1));
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(refPtr));
  p_touch_clears_age_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> age[$past(rowIdx)] == '0);
  p_retention_r9: assert property (@(posedge clk) disable iff (!rstN)
    !anyExpired);
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROWS      = 128,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqEn,
  input  logic              reqWe,
  input  logic [BANK_W-1:0] bankIdx,
  input  logic [ROW_W-1:0]  rowIdx,
  output strobe_t           strobes,
  output logic [BANK_W-1:0] wbBank
);
  logic              cacheValid [ROWS];
  logic              cacheDirty [ROWS];
  logic [BANK_W-1:0] cacheTag   [ROWS];
  logic              hit, miss, armed;

  assign hit    = reqEn && cacheValid[rowIdx] && (cacheTag[rowIdx] == bankIdx);
  assign miss   = reqEn && !hit;
  assign wbBank = cacheTag[rowIdx];

  always_comb begin
    strobes.access      = miss;
    strobes.accessWrite = miss && reqWe;
    strobes.writeback   = miss && cacheValid[rowIdx] && cacheDirty[rowIdx];
    strobes.hitWrite    = hit && reqWe;
    strobes.readHit     = hit && !reqWe;
    strobes.readMiss    = miss && !reqWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) begin
        cacheValid[r] <= 1'b0;
        cacheDirty[r] <= 1'b0;
        cacheTag[r]   <= '0;
      end
    end else if (miss) begin
      cacheValid[rowIdx] <= 1'b1;
      cacheDirty[rowIdx] <= 1'b0;
      cacheTag[rowIdx]   <= bankIdx;
    end else if (hit && reqWe) begin
      cacheDirty[rowIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  p_fill_then_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && reqEn && $past(miss) && bankIdx == $past(bankIdx) && rowIdx == $past(rowIdx)) |-> hit);
endmodule

// File: rtl/psram_datapath.sv
module psram_datapath
  import psram_pkg::*;
#(
  parameter int NUM_BANKS        = 4,
  parameter int ROWS             = 128,
  parameter int ROW_BITS         = 256,
  parameter int WORD_BITS        = 32,
  parameter int RETENTION_CYCLES = 1024,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int WORD_W = $clog2(ROW_BITS / WORD_BITS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic [BANK_W-1:0]    wbBank,
  input  logic [BANK_W-1:0]    bankIdx,
  input  logic [ROW_W-1:0]     rowIdx,
  input  logic [WORD_W-1:0]    wordIdx,
  input  logic [WORD_BITS-1:0] wrData,
  output logic [WORD_BITS-1:0] rdData
);
  logic [ROW_BITS-1:0]  cacheData [ROWS];
  logic [ROW_BITS-1:0]  bankRows  [NUM_BANKS];
  logic [ROW_BITS-1:0]  openRow, mergedRow, cachedRow;
  logic [NUM_BANKS-1:0] bankBusy;

  assign openRow   = bankRows[bankIdx];
  assign cachedRow = cacheData[rowIdx];

  always_comb begin
    mergedRow = openRow;
    if (strobes.accessWrite) mergedRow[wordIdx*WORD_BITS +: WORD_BITS] = wrData;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic isOpen, isWb;
    assign isOpen      = strobes.access && (bankIdx == BANK_W'(g));
    assign isWb        = strobes.writeback && (wbBank == BANK_W'(g));
    assign bankBusy[g] = isOpen || isWb;

    psram_bank #(
      .ROWS(ROWS), .ROW_BITS(ROW_BITS), .RETENTION_CYCLES(RETENTION_CYCLES)
    ) uBank (
      .clk   (clk),
      .rstN  (rstN),
      .busy  (bankBusy[g]),
      .rowWe ((isOpen && strobes.accessWrite) || isWb),
      .rowIdx(rowIdx),
      .rowIn (isWb ? cachedRow : mergedRow),
      .rowOut(bankRows[g])
    );
  end

  always_ff @(posedge clk) begin
    if (strobes.access)        cacheData[rowIdx] <= mergedRow;
    else if (strobes.hitWrite) cacheData[rowIdx][wordIdx*WORD_BITS +: WORD_BITS] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 rdData <= '0;
    else if (strobes.readHit)  rdData <= cachedRow[wordIdx*WORD_BITS +: WORD_BITS];
    else if (strobes.readMiss) rdData <= openRow[wordIdx*WORD_BITS +: WORD_BITS];
  end

  p_two_banks_max_r9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(bankBusy) <= 2);
  p_wb_other_bank_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeback && strobes.access) |-> (wbBank != bankIdx));
endmodule

// File: rtl/psram_refresh_hider.sv
module psram_refresh_hider
  import psram_pkg::*;
#(
  parameter int NUM_BANKS        = 4,
  parameter int ROWS             = 128,
  parameter int ROW_BITS         = 256,
  parameter int WORD_BITS        = 32,
  parameter int RETENTION_CYCLES = 1024,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int WORD_W = $clog2(ROW_BITS / WORD_BITS),
  localparam int ADDR_W = BANK_W + ROW_W + WORD_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqEn,
  input  logic                 reqWe,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [WORD_BITS-1:0] wrData,
  output logic [WORD_BITS-1:0] rdData
);
  logic [BANK_W-1:0] bankIdx, wbBank;
  logic [ROW_W-1:0]  rowIdx;
  logic [WORD_W-1:0] wordIdx;
  strobe_t           strobes;

  assign {bankIdx, rowIdx, wordIdx} = reqAddr;

  psram_ctrl #(.NUM_BANKS(NUM_BANKS), .ROWS(ROWS)) uCtrl (
    .clk(clk), .rstN(rstN), .reqEn(reqEn), .reqWe(reqWe),
    .bankIdx(bankIdx), .rowIdx(rowIdx), .strobes(strobes), .wbBank(wbBank)
  );

  psram_datapath #(
    .NUM_BANKS(NUM_BANKS), .ROWS(ROWS), .ROW_BITS(ROW_BITS),
    .WORD_BITS(WORD_BITS), .RETENTION_CYCLES(RETENTION_CYCLES)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wbBank(wbBank),
    .bankIdx(bankIdx), .rowIdx(rowIdx), .wordIdx(wordIdx),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/psram_refresh_hider_test.sv
module psram_refresh_hider_test;
  localparam int ADDR_W = 12;
  localparam int WB     = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqEn = 1'b0;
  logic          reqWe = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [WB-1:0] wrData = '0;
  logic [WB-1:0] rdData;

  int checks = 0;
  int errors = 0;
  logic [WB-1:0] model [int];

  always #10 clk = ~clk;

  psram_refresh_hider uut (
    .clk(clk), .rstN(rstN), .reqEn(reqEn), .reqWe(reqWe),
    .reqAddr(reqAddr), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [ADDR_W-1:0] mkAddr(int b, int r, int w);
    return {b[1:0], r[6:0], w[2:0]};
  endfunction

  task automatic checkEq(logic [WB-1:0] got, logic [WB-1:0] exp, string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic doWrite(logic [ADDR_W-1:0] a, logic [WB-1:0] d);
    @(negedge clk);
    reqEn = 1'b1; reqWe = 1'b1; reqAddr = a; wrData = d;
    model[int'(a)] = d;
    @(posedge clk); #1;
  endtask

  task automatic doRead(logic [ADDR_W-1:0] a, string req);
    @(negedge clk);
    reqEn = 1'b1; reqWe = 1'b0; reqAddr = a;
    @(posedge clk); #1;
    checkEq(rdData, model[int'(a)], req);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    reqEn = 1'b0; reqWe = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // R1: reset state of the read port
  task automatic testReset();
    repeat (4) @(posedge clk);
    #1 checkEq(rdData, '0, "R1 during reset");
    @(negedge clk) rstN = 1'b1;
    idle(5);
    checkEq(rdData, '0, "R1 after reset");
  endtask

  // R2: decode and one-cycle latency
  task automatic testDecode();
    doWrite(mkAddr(0, 0, 0), 32'h1111_0000);
    doWrite(mkAddr(3, 127, 7), 32'h3333_7f07);
    doWrite(mkAddr(1, 64, 5), 32'h1234_5678);
    doRead(mkAddr(0, 0, 0), "R2");
    doRead(mkAddr(3, 127, 7), "R2");
    doRead(mkAddr(1, 64, 5), "R2");
  endtask

  // R3: word merge inside a row
  task automatic testMerge();
    for (int w = 0; w < 8; w++) doWrite(mkAddr(2, 40, w), 32'hA000_0000 + w);
    idle(1);
    doWrite(mkAddr(2, 40, 3), 32'hDEAD_BEEF);
    for (int w = 0; w < 8; w++) doRead(mkAddr(2, 40, w), "R3");
  endtask

  // R4: same row index in every bank is independent
  task automatic testAlias();
    for (int b = 0; b < 4; b++) doWrite(mkAddr(b, 10, 1), 32'hB0B0_0000 + b);
    for (int b = 3; b >= 0; b--) doRead(mkAddr(b, 10, 1), "R4");
  endtask

  // R5: dirty entry written back on eviction
  task automatic testEvict();
    doWrite(mkAddr(2, 20, 0), 32'h0000_00AA);
    doWrite(mkAddr(1, 20, 0), 32'h0000_00BB);
    doWrite(mkAddr(1, 20, 1), 32'h0000_00CC);
    doRead(mkAddr(2, 20, 0), "R5 evicting read");
    doRead(mkAddr(1, 20, 1), "R5 written-back word");
    doRead(mkAddr(1, 20, 0), "R5 other word");
  endtask

  // R6: read data held across writes and idle
  task automatic testHold();
    doRead(mkAddr(1, 64, 5), "R6 setup");
    doWrite(mkAddr(0, 5, 2), 32'h5555_0002);
    checkEq(rdData, 32'h1234_5678, "R6 after write");
    idle(3);
    checkEq(rdData, 32'h1234_5678, "R6 after idle");
  endtask

  // R7: back-to-back requests
  task automatic testStream();
    for (int i = 0; i < 16; i++) doWrite(mkAddr(i % 4, 90 + i, i % 8), 32'hC0DE_0000 + i);
    for (int i = 0; i < 16; i++) doRead(mkAddr(i % 4, 90 + i, i % 8), "R7");
  endtask

  // R8: long idle stretch, refresh keeps contents
  task automatic testIdleRefresh();
    idle(600);
    foreach (model[k]) doRead(ADDR_W'(k), "R8");
  endtask

  // R9: hammer one row, then sweep misses with evictions, then read back
  task automatic testHammer();
    for (int i = 0; i < 1500; i++) doWrite(mkAddr(0, 3, i % 8), 32'hF000_0000 + i);
    for (int i = 0; i < 512; i++) begin
      doWrite(mkAddr(1, i % 128, i / 128), 32'hE000_0000 + i);
      doWrite(mkAddr(2, i % 128, 6), 32'hD000_0000 + i);
    end
    foreach (model[k]) doRead(ADDR_W'(k), "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testDecode();
    testMerge();
    testAlias();
    testEvict();
    testHold();
    testStream();
    testIdleRefresh();
    testHammer();
    idle(2);
    finishRun();
  end
endmodule